// File: doc/BRIEF.md
# Serial Audio DAC Word Transmitter

This block accepts signed two's-complement PCM samples on a parallel valid/ready port and sends them serially to a latch-strobed audio converter. It produces three kinds of line: a bit clock, one data line per channel, and an active-low latch strobe. A word of `WORD_W` bits goes out most significant bit first. The converter captures the data line on each rising edge of the bit clock. Data lines change only at falling edges. When the last bit has been sent, a low pulse on the latch line moves the word into the converter's input register. With `DUAL` set, the left and right samples are taken as one pair. They go out at the same time on two data lines, which share one bit clock and one latch strobe.

The bit clock is divided down from the system clock. Each phase, high or low, lasts `cfg_half_period` system cycles, and values below 2 count as 2. This gives every sampling edge at least two cycles of setup and two cycles of hold. The latch pulse width is set by `cfg_latch_len`, and 0 counts as 1. Both settings are captured when a sample is accepted and hold for that whole word.

Back-pressure: `s_ready` is high only while the transmitter is idle. It goes low on the cycle after a handshake (`s_valid && s_ready` at a rising clock edge) and stays low until the latch strobe has returned high. The source may hold `s_valid` high with the next sample for as long as it likes. That sample is taken on the first idle cycle, and its data and settings are read only at that handshake edge.

Top module: `audio_dac_tx`

## Requirements
- R1: Each accepted sample appears on its data line as exactly `WORD_W` bits, most significant bit first, one bit per rising edge of `dac_bclk`. The bits captured on those rising edges reproduce the sample bit for bit, including sign.
- R2: A data line never changes in a cycle in which `dac_bclk` is high. Values change only at the falling edge of `dac_bclk`, in the latch phase or at load.
- R3: Each high phase and each low phase of `dac_bclk` within a word lasts `cfg_half_period` system cycles. Any setting below 2 is treated as 2.
- R4: `dac_le_n` falls at the same edge as the final falling edge of `dac_bclk`, one half period after the last rising edge. It then stays low for exactly `cfg_latch_len` cycles, with 0 treated as 1. `dac_bclk` stays low while the strobe is low.
- R5: `s_ready` is high only when idle. It drops on the cycle after a handshake and stays low until the latch strobe has risen. A sample presented while busy is neither taken nor able to disturb the word in flight.
- R6: `cfg_half_period` and `cfg_latch_len` are sampled at the handshake. Changing them while a word is in flight has no effect on that word.
- R7: In dual mode the right sample goes out on `dac_sdata_r`, bit-aligned with the left sample on `dac_sdata_l`, under the same clock and strobe.
- R8: Between words `dac_bclk` rests low and `dac_le_n` rests high.
- R9: A synchronous active-high `rst` drives `dac_bclk` low, `dac_le_n` high and both data lines low. It discards any partly sent word, so no latch pulse follows. The next accepted word is sent whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_period | input | HALF_W | Bit-clock half period in system cycles (min 2) |
| cfg_latch_len | input | LEN_W | Latch strobe low width in system cycles (min 1) |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Transmitter idle, ready to accept |
| s_data_l | input | WORD_W | Left (or only) sample, two's complement |
| s_data_r | input | WORD_W | Right sample, used in dual mode |
| dac_bclk | output | 1 | Serial bit clock to the converter |
| dac_le_n | output | 1 | Active-low latch strobe |
| dac_sdata_l | output | 1 | Left serial data line |
| dac_sdata_r | output | 1 | Right serial data line (low when not dual) |

## Verification
The assertions assume that `rst` is high from time zero until after the first clock edge. They also assume that the inputs stay settled around each rising system-clock edge, so that `s_data_*` and the two settings are read as one coherent set at the handshake. The stimulus drives every input shortly after a falling system-clock edge and starts with reset held high. It changes the settings or the offered sample only at moments where the requirements say they must be ignored. The bench rebuilds the received words and the phase widths from the pins alone, sampling on falling system-clock edges.

// File: rtl/dactx_pkg.sv
package dactx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LATCH = 2'd3
  } dactx_state_e;

  localparam int unsigned MIN_HALF_CYC  = 2;
  localparam int unsigned MIN_LATCH_CYC = 1;
endpackage

// File: rtl/dactx_phase_timer.sv
module dactx_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + CNT_W'(1);
  end

  // limit is never below 1: the sequencer clamps it
  assign expire = (cnt == (limit - CNT_W'(1)));
endmodule

// File: rtl/dactx_shifter.sv
module dactx_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] din,
  output logic              bit_out
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)        shreg <= '0;
    else if (load)  shreg <= din;
    else if (shift) shreg <= {shreg[WORD_W-2:0], 1'b0};
  end

  assign bit_out = shreg[WORD_W-1];
endmodule

// File: rtl/dactx_seq.sv
module dactx_seq
  import dactx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int HALF_W = 8,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              load,
  output logic              shift,
  output logic              bclk,
  output logic              le_n
);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  dactx_state_e     state, nxt;
  logic [BIT_W-1:0] bit_idx;
  logic [CNT_W-1:0] half_q, len_q, half_eff, len_eff, limit;
  logic             clr, expire, last_bit;

  assign half_eff = (cfg_half < HALF_W'(MIN_HALF_CYC)) ? CNT_W'(MIN_HALF_CYC) : CNT_W'(cfg_half);
  assign len_eff  = (cfg_len == '0) ? CNT_W'(MIN_LATCH_CYC) : CNT_W'(cfg_len);
  assign last_bit = (bit_idx == BIT_W'(WORD_W - 1));
  assign limit    = (state == ST_LATCH) ? len_q : half_q;

  dactx_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .limit  (limit),
    .expire (expire)
  );

  always_comb begin
    nxt     = state;
    load    = 1'b0;
    shift   = 1'b0;
    clr     = 1'b0;
    s_ready = 1'b0;
    unique case (state)
      ST_IDLE: begin
        s_ready = !rst;
        if (s_valid && !rst) begin
          load = 1'b1;
          clr  = 1'b1;
          nxt  = ST_LOW;
        end
      end
      ST_LOW: begin
        if (expire) begin
          clr = 1'b1;
          nxt = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (expire) begin
          clr = 1'b1;
          if (last_bit) nxt = ST_LATCH;
          else begin
            shift = 1'b1;
            nxt   = ST_LOW;
          end
        end
      end
      ST_LATCH: begin
        if (expire) begin
          clr = 1'b1;
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      half_q  <= CNT_W'(MIN_HALF_CYC);
      len_q   <= CNT_W'(MIN_LATCH_CYC);
      bclk    <= 1'b0;
      le_n    <= 1'b1;
    end else begin
      state <= nxt;
      bclk  <= (nxt == ST_HIGH);
      le_n  <= (nxt != ST_LATCH);
      if (load) begin
        bit_idx <= '0;
        half_q  <= half_eff;
        len_q   <= len_eff;
      end else if (shift) begin
        bit_idx <= bit_idx + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/audio_dac_tx.sv
module audio_dac_tx #(
  parameter int WORD_W = 16,
  parameter bit DUAL   = 1'b1,
  parameter int HALF_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] cfg_half_period,
  input  logic [LEN_W-1:0]  cfg_latch_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data_l,
  input  logic [WORD_W-1:0] s_data_r,
  output logic              dac_bclk,
  output logic              dac_le_n,
  output logic              dac_sdata_l,
  output logic              dac_sdata_r
);
  localparam int NUM_CH = DUAL ? 2 : 1;
  localparam int CNT_W  = (HALF_W > LEN_W) ? HALF_W : LEN_W;

  logic              load, shift;
  logic [WORD_W-1:0] ch_data [NUM_CH];
  logic [NUM_CH-1:0] ch_bit;

  dactx_seq #(
    .WORD_W (WORD_W),
    .HALF_W (HALF_W),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cfg_half (cfg_half_period),
    .cfg_len  (cfg_latch_len),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .load     (load),
    .shift    (shift),
    .bclk     (dac_bclk),
    .le_n     (dac_le_n)
  );

  assign ch_data[0]  = s_data_l;
  assign dac_sdata_l = ch_bit[0];

  generate
    if (NUM_CH == 2) begin : g_dual
      assign ch_data[1]  = s_data_r;
      assign dac_sdata_r = ch_bit[1];
    end else begin : g_mono
      assign dac_sdata_r = 1'b0;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dactx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .shift   (shift),
        .din     (ch_data[c]),
        .bit_out (ch_bit[c])
      );
    end
  endgenerate
endmodule

// File: rtl/dactx_checker.sv
module dactx_checker (
  input logic clk,
  input logic rst,
  input logic s_valid,
  input logic s_ready,
  input logic dac_bclk,
  input logic dac_le_n,
  input logic dac_sdata_l,
  input logic dac_sdata_r
);
  // R2: data held through every cycle the bit clock is high
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
    dac_bclk |-> ($stable(dac_sdata_l) && $stable(dac_sdata_r)));

  // R3: each bit-clock phase spans at least two cycles
  assert_high_min_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_bclk) |=> dac_bclk);
  assert_low_min_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_bclk) |=> !dac_bclk);

  // R4: strobe starts with the last falling clock edge, clock parked low during it
  assert_latch_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_le_n) |-> $fell(dac_bclk));
  assert_latch_clk_low_R4: assert property (@(posedge clk) disable iff (rst)
    !dac_le_n |-> !dac_bclk);

  // R5: a handshake drops ready
  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  // R8: idle lines while ready
  assert_idle_lines_R8: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (dac_le_n && !dac_bclk));

  // R9: reset forces the idle line state
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (dac_le_n && !dac_bclk && !dac_sdata_l && !dac_sdata_r));
endmodule

bind audio_dac_tx dactx_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .dac_bclk    (dac_bclk),
  .dac_le_n    (dac_le_n),
  .dac_sdata_l (dac_sdata_l),
  .dac_sdata_r (dac_sdata_r)
);

// File: tb/tb_audio_dac_tx.sv
module tb_audio_dac_tx;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int NVEC       = 5;
  localparam int WATCHDOG   = 100000;

  localparam logic [W-1:0] VEC_L [NVEC] = '{16'hA5C3, 16'h8000, 16'hFFFF, 16'h1234, 16'h0000};
  localparam logic [W-1:0] VEC_R [NVEC] = '{16'h5A3C, 16'h7FFF, 16'h0001, 16'hFEDC, 16'hFFFF};
  localparam logic [7:0]   VEC_H [NVEC] = '{8'd2, 8'd3, 8'd0, 8'd5, 8'd1};
  localparam logic [7:0]   VEC_E [NVEC] = '{8'd1, 8'd4, 8'd0, 8'd2, 8'd3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg_half_period = 8'd2;
  logic [7:0] cfg_latch_len = 8'd1;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [W-1:0] s_data_l = '0;
  logic [W-1:0] s_data_r = '0;
  logic dac_bclk, dac_le_n, dac_sdata_l, dac_sdata_r;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  audio_dac_tx #(.WORD_W(W), .DUAL(1'b1), .HALF_W(8), .LEN_W(8)) dut (
    .clk(clk), .rst(rst),
    .cfg_half_period(cfg_half_period), .cfg_latch_len(cfg_latch_len),
    .s_valid(s_valid), .s_ready(s_ready),
    .s_data_l(s_data_l), .s_data_r(s_data_r),
    .dac_bclk(dac_bclk), .dac_le_n(dac_le_n),
    .dac_sdata_l(dac_sdata_l), .dac_sdata_r(dac_sdata_r)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // pin-level receiver model, sampled on falling system-clock edges
  logic [W-1:0] sh_l = '0, sh_r = '0, got_l = '0, got_r = '0;
  int bits = 0, got_bits = 0, hi_run = 0, hi_len = 0, lo_run = 0, lo_len = 0;
  int le_run = 0, le_len = 0, since_rise = 0, hold_len = 0, viol = 0, latches = 0;
  logic prev_bclk = 1'b0, prev_le = 1'b1, prev_dl = 1'b0, prev_dr = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      bits = 0; hi_run = 0; lo_run = 0; le_run = 0;
    end else begin
      if (dac_bclk && ((dac_sdata_l != prev_dl) || (dac_sdata_r != prev_dr))) viol++;
      if (dac_bclk && !prev_bclk) begin
        if (bits > 0) lo_len = lo_run;
        lo_run = 0;
        sh_l = {sh_l[W-2:0], dac_sdata_l};
        sh_r = {sh_r[W-2:0], dac_sdata_r};
        bits++;
        since_rise = 0;
        hi_run = 1;
      end else begin
        since_rise++;
        if (dac_bclk) hi_run++;
        else lo_run++;
        if (!dac_bclk && prev_bclk) hi_len = hi_run;
      end
      if (!dac_le_n && prev_le) begin
        got_l = sh_l; got_r = sh_r; got_bits = bits; bits = 0;
        hold_len = since_rise; le_run = 1;
      end else if (!dac_le_n) begin
        le_run++;
      end else if (dac_le_n && !prev_le) begin
        le_len = le_run;
        latches++;
      end
    end
    prev_bclk = dac_bclk; prev_le = dac_le_n; prev_dl = dac_sdata_l; prev_dr = dac_sdata_r;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: act=%0d expected below %0d cycles", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic int eff_half(input logic [7:0] h);
    return (h < 8'd2) ? 2 : int'(h);
  endfunction

  function automatic int eff_len(input logic [7:0] e);
    return (e == 8'd0) ? 1 : int'(e);
  endfunction

  // sends one pair and checks everything observable about its transfer
  task automatic send_check(input logic [W-1:0] l, input logic [W-1:0] r,
                            input logic [7:0] h, input logic [7:0] e,
                            input bit meddle, input bit keep,
                            input logic [W-1:0] nl, input logic [W-1:0] nr);
    int start;
    int busy_ready;
    int v0;
    start = latches;
    v0 = viol;
    busy_ready = 0;
    while (!s_ready) step();
    s_data_l = l; s_data_r = r; cfg_half_period = h; cfg_latch_len = e; s_valid = 1'b1;
    step();
    if (keep) begin
      s_data_l = nl; s_data_r = nr;
    end else begin
      s_valid = 1'b0;
    end
    if (meddle) begin
      cfg_half_period = 8'd7; cfg_latch_len = 8'd9;
    end
    while (latches == start) begin
      if (s_ready) busy_ready++;
      step();
    end
    check("R1 left word", 32'(got_l), 32'(l));
    check("R7 right word", 32'(got_r), 32'(r));
    check("R1 bit count", 32'(got_bits), 32'(W));
    check("R3 high phase", 32'(hi_len), 32'(eff_half(h)));
    check("R3 low phase", 32'(lo_len), 32'(eff_half(h)));
    check("R4 hold before strobe", 32'(hold_len), 32'(eff_half(h)));
    check("R4 strobe width", 32'(le_len), 32'(eff_len(e)));
    check("R5 ready low while busy", 32'(busy_ready), 32'd0);
    check("R2 data stable while clock high", 32'(viol - v0), 32'd0);
    check("R8 idle lines", {30'd0, dac_bclk, dac_le_n}, 32'd1);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) step();
    // R9 / R8 reset state
    check("R9 bclk in reset", 32'(dac_bclk), 32'd0);
    check("R9 le_n in reset", 32'(dac_le_n), 32'd1);
    check("R9 data in reset", {30'd0, dac_sdata_l, dac_sdata_r}, 32'd0);
    rst = 1'b0;
    step();
    check("R5 ready after reset", 32'(s_ready), 32'd1);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      send_check(VEC_L[i], VEC_R[i], VEC_H[i], VEC_E[i], 1'b0, 1'b0, '0, '0);
    end

    // R6: settings changed mid-word do not affect the word in flight
    send_check(16'hC0DE, 16'h0F0F, 8'd3, 8'd2, 1'b1, 1'b0, '0, '0);

    // R5: next pair offered during a word is taken only afterwards, unchanged word in flight
    send_check(16'h6B1D, 16'h94E2, 8'd2, 8'd2, 1'b0, 1'b1, 16'h3C3C, 16'hC3C3);
    begin
      int start2;
      start2 = latches;
      step();
      check("R5 held offer accepted", 32'(s_ready), 32'd0);
      s_valid = 1'b0;
      while (latches == start2) step();
      check("R5 second word left", 32'(got_l), 32'h3C3C);
      check("R5 second word right", 32'(got_r), 32'hC3C3);
      check("R5 second word bits", 32'(got_bits), 32'(W));
    end

    // R9: reset in the middle of a word discards it
    begin
      int lat0;
      while (!s_ready) step();
      s_data_l = 16'hFFFF; s_data_r = 16'hFFFF; cfg_half_period = 8'd2; cfg_latch_len = 8'd1;
      s_valid = 1'b1;
      step();
      s_valid = 1'b0;
      while (bits < 5) step();
      lat0 = latches;
      rst = 1'b1;
      step();
      step();
      check("R9 bclk after mid-word reset", 32'(dac_bclk), 32'd0);
      check("R9 le_n after mid-word reset", 32'(dac_le_n), 32'd1);
      check("R9 data after mid-word reset", {30'd0, dac_sdata_l, dac_sdata_r}, 32'd0);
      rst = 1'b0;
      repeat (10) step();
      check("R9 no strobe for discarded word", 32'(latches - lat0), 32'd0);
      send_check(16'h2468, 16'hDB97, 8'd2, 8'd1, 1'b0, 1'b0, '0, '0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule